// File: doc/BRIEF.md
# Dual-Port RAM with Per-Port Address Hold

A synchronous two-port memory in which every port keeps its own address register. On each rising clock edge a port normally loads the address on its bus and uses it for that edge's read or write. A per-port hold input freezes the register instead. While the hold is high, the port keeps reading or writing the word it last addressed, whatever the address bus is doing. This lets a pipeline keep re-reading a location, or keep writing it, without holding its address bus steady.

Each port has its own read enable, write enable, write data and hold input. Both ports share one clock. Read data leaves the block either straight from the read register that follows the array, or through an extra output register that a parameter enables. A synchronous reset clears the address, read and output registers and leaves the array contents alone.

Top module: `dpram_stall`

## Requirements
- R1: With the hold input low, a port loads its address bus into its address register at each rising edge, and that edge's read or write uses the new address.
- R2: With the hold input high, a port's address register keeps its value, and reads at that edge return the word at the held address.
- R3: A write at an edge where the port's hold input is high goes to the held address, not to the address on the bus.
- R4: The hold inputs are independent: holding one port does not change the address register or data of the other port.
- R5: When the hold input falls, the address on the bus at that same edge is loaded and used, with no lost cycle.
- R6: With the output register off, read data is valid after the edge at which the read enable was sampled high. With it on, read data is valid one edge later.
- R7: At an edge where the read enable is low, the read register keeps its value. The output register keeps its value at the following edge.
- R8: When both ports write the same effective address at the same edge, the word stored is port A's write data.
- R9: A read at an edge where either port writes the same effective address returns the word held before that write.
- R10: A synchronous reset sets both address registers to 0 and clears the read and output registers to 0. It does not change the array contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous reset, active high |
| a_addr | input | AW | Port A address bus |
| a_hold | input | 1 | Port A address hold (1 = keep latched address) |
| a_re | input | 1 | Port A read enable |
| a_we | input | 1 | Port A write enable |
| a_wdata | input | DW | Port A write data |
| a_rdata | output | DW | Port A read data |
| b_addr | input | AW | Port B address bus |
| b_hold | input | 1 | Port B address hold (1 = keep latched address) |
| b_re | input | 1 | Port B read enable |
| b_we | input | 1 | Port B write enable |
| b_wdata | input | DW | Port B write data |
| b_rdata | output | DW | Port B read data |

## Verification
A write lands in the array at the edge where it is presented. An address or hold change affects the edge at which it is sampled. Read data from the direct path is due after that same edge, and read data from the output register is due after the next one. The bench drives one instance of each output variant from the same inputs and steps a model through every edge using the rules above. It compares both variants half a period after each edge, so every sample falls where each variant's latency places its result.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
    localparam int DW_DEFAULT = 8;
    localparam int AW_DEFAULT = 4;
    localparam int NUM_PORTS  = 2;
endpackage

// File: rtl/dpram_addr_latch.sv
module dpram_addr_latch #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] eff,
    output logic [AW-1:0] lat
);
    typedef struct packed {
        logic [AW-1:0] addr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!hold) st_d.addr = addr;
        if (rst)   st_d.addr = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // address used by the current edge: the bus unless held
    assign eff = hold ? st_q.addr : addr;
    assign lat = st_q.addr;
endmodule

// File: rtl/dpram_rd_stage.sv
module dpram_rd_stage #(
    parameter int DW      = 8,
    parameter bit OUT_REG = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          re,
    input  logic [DW-1:0] word,
    output logic [DW-1:0] raw,
    output logic [DW-1:0] q
);
    typedef struct packed {
        logic [DW-1:0] rdata;
        logic [DW-1:0] oreg;
        logic          re_q;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.re_q = re;
        if (re)       st_d.rdata = word;
        if (st_q.re_q) st_d.oreg = st_q.rdata;
        if (rst) begin
            st_d.rdata = '0;
            st_d.oreg  = '0;
            st_d.re_q  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign raw = st_q.rdata;
    assign q   = OUT_REG ? st_q.oreg : st_q.rdata;
endmodule

// File: rtl/dpram_stall.sv
module dpram_stall
    import dpram_pkg::*;
#(
    parameter int DW      = DW_DEFAULT,
    parameter int AW      = AW_DEFAULT,
    parameter bit OUT_REG = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] a_addr,
    input  logic          a_hold,
    input  logic          a_re,
    input  logic          a_we,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic [AW-1:0] b_addr,
    input  logic          b_hold,
    input  logic          b_re,
    input  logic          b_we,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [AW-1:0] addr_w [NUM_PORTS];
    logic          hold_w [NUM_PORTS];
    logic          re_w   [NUM_PORTS];
    logic [AW-1:0] eff_w  [NUM_PORTS];
    logic [AW-1:0] lat_w  [NUM_PORTS];
    logic [DW-1:0] word_w [NUM_PORTS];
    logic [DW-1:0] raw_w  [NUM_PORTS];
    logic [DW-1:0] q_w    [NUM_PORTS];

    logic [DW-1:0] mem [DEPTH];

    assign addr_w[0] = a_addr;
    assign addr_w[1] = b_addr;
    assign hold_w[0] = a_hold;
    assign hold_w[1] = b_hold;
    assign re_w[0]   = a_re;
    assign re_w[1]   = b_re;
    assign a_rdata   = q_w[0];
    assign b_rdata   = q_w[1];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        dpram_addr_latch #(.AW(AW)) u_lat (
            .clk  (clk),
            .rst  (rst),
            .hold (hold_w[p]),
            .addr (addr_w[p]),
            .eff  (eff_w[p]),
            .lat  (lat_w[p])
        );

        // read before write: the array word is sampled before this edge's update
        assign word_w[p] = mem[eff_w[p]];

        dpram_rd_stage #(.DW(DW), .OUT_REG(OUT_REG)) u_rd (
            .clk  (clk),
            .rst  (rst),
            .re   (re_w[p]),
            .word (word_w[p]),
            .raw  (raw_w[p]),
            .q    (q_w[p])
        );
    end

    // port B first so that port A's write overrides on a shared address
    always_ff @(posedge clk) begin
        if (b_we) mem[eff_w[1]] <= b_wdata;
        if (a_we) mem[eff_w[0]] <= a_wdata;
    end
endmodule

module dpram_stall_chk #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          a_hold,
    input logic          b_hold,
    input logic          a_re,
    input logic          b_re,
    input logic [AW-1:0] a_addr,
    input logic [AW-1:0] b_addr,
    input logic [AW-1:0] a_lat,
    input logic [AW-1:0] b_lat,
    input logic [DW-1:0] a_raw,
    input logic [DW-1:0] b_raw
);
    // R1
    a_load_chk: assert property (@(posedge clk) disable iff (rst)
        !a_hold |=> (a_lat == $past(a_addr)));
    // R1
    b_load_chk: assert property (@(posedge clk) disable iff (rst)
        !b_hold |=> (b_lat == $past(b_addr)));
    // R2
    a_hold_chk: assert property (@(posedge clk) disable iff (rst)
        a_hold |=> $stable(a_lat));
    // R4
    b_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (b_hold && !a_hold) |=> ($stable(b_lat) && (a_lat == $past(a_addr))));
    // R7
    a_rd_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !a_re |=> $stable(a_raw));
    // R7
    b_rd_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !b_re |=> $stable(b_raw));
    // R10
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (a_lat == '0 && b_lat == '0 && a_raw == '0 && b_raw == '0));
endmodule

bind dpram_stall dpram_stall_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .a_hold (a_hold),
    .b_hold (b_hold),
    .a_re   (a_re),
    .b_re   (b_re),
    .a_addr (a_addr),
    .b_addr (b_addr),
    .a_lat  (lat_w[0]),
    .b_lat  (lat_w[1]),
    .a_raw  (raw_w[0]),
    .b_raw  (raw_w[1])
);

// File: tb/dpram_stall_tb.sv
module dpram_stall_tb;
    localparam int PERIOD = 10;
    localparam int DW = 8;
    localparam int AW = 4;
    localparam int N  = 14;

    typedef struct packed {
        logic          wa, ha, ra;
        logic [AW-1:0] aa;
        logic [DW-1:0] da;
        logic          wb, hb, rb;
        logic [AW-1:0] ab;
        logic [DW-1:0] db;
    } vec_t;

    // stimulus per edge; expectations come from the model below
    localparam vec_t VEC [N] = '{
        '{1'b1,1'b0,1'b0,4'd1,8'h11, 1'b1,1'b0,1'b0,4'd2,8'h22},
        '{1'b1,1'b0,1'b0,4'd3,8'h33, 1'b1,1'b0,1'b0,4'd4,8'h44},
        '{1'b0,1'b0,1'b1,4'd1,8'h00, 1'b0,1'b0,1'b1,4'd2,8'h00},
        '{1'b0,1'b1,1'b1,4'd3,8'h00, 1'b0,1'b0,1'b1,4'd4,8'h00},
        '{1'b1,1'b1,1'b0,4'd7,8'h55, 1'b0,1'b0,1'b1,4'd3,8'h00},
        '{1'b0,1'b0,1'b1,4'd1,8'h00, 1'b0,1'b0,1'b1,4'd1,8'h00},
        '{1'b1,1'b0,1'b0,4'd6,8'h66, 1'b1,1'b0,1'b0,4'd6,8'h99},
        '{1'b0,1'b0,1'b1,4'd6,8'h00, 1'b0,1'b1,1'b1,4'd9,8'h00},
        '{1'b0,1'b0,1'b1,4'd6,8'h00, 1'b1,1'b0,1'b0,4'd6,8'h77},
        '{1'b0,1'b0,1'b0,4'd1,8'h00, 1'b0,1'b0,1'b1,4'd6,8'h00},
        '{1'b0,1'b0,1'b1,4'd3,8'h00, 1'b0,1'b1,1'b0,4'd0,8'h00},
        '{1'b1,1'b0,1'b1,4'd3,8'hA3, 1'b0,1'b0,1'b1,4'd2,8'h00},
        '{1'b0,1'b0,1'b1,4'd3,8'h00, 1'b1,1'b1,1'b0,4'd0,8'hBB},
        '{1'b0,1'b0,1'b1,4'd2,8'h00, 1'b0,1'b0,1'b1,4'd2,8'h00}
    };

    function automatic string tag(input int i);
        case (i)
            0, 1:   return "R1 write";
            2:      return "R6 read latency";
            3:      return "R2 held read";
            4:      return "R3 held write";
            5:      return "R5 release";
            6:      return "R8 A wins";
            7:      return "R4 independent hold";
            8:      return "R9 old data";
            9:      return "R7 read enable low";
            10:     return "R7 hold B idle";
            11:     return "R9 same-port write";
            12:     return "R3 held write B";
            default: return "R1 read back";
        endcase
    endfunction

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] a_addr, b_addr;
    logic          a_hold, a_re, a_we, b_hold, b_re, b_we;
    logic [DW-1:0] a_wdata, b_wdata;
    logic [DW-1:0] a_q, b_q, a_r, b_r;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // model state
    logic [DW-1:0] m [1<<AW];
    logic [AW-1:0] la, lb;
    logic [DW-1:0] ra, rb, oa, ob;
    logic          rqa, rqb;

    always #(PERIOD/2) clk = ~clk;

    dpram_stall #(.DW(DW), .AW(AW), .OUT_REG(1'b1)) u_dut (
        .clk(clk), .rst(rst),
        .a_addr(a_addr), .a_hold(a_hold), .a_re(a_re), .a_we(a_we), .a_wdata(a_wdata), .a_rdata(a_q),
        .b_addr(b_addr), .b_hold(b_hold), .b_re(b_re), .b_we(b_we), .b_wdata(b_wdata), .b_rdata(b_q)
    );

    dpram_stall #(.DW(DW), .AW(AW), .OUT_REG(1'b0)) u_raw (
        .clk(clk), .rst(rst),
        .a_addr(a_addr), .a_hold(a_hold), .a_re(a_re), .a_we(a_we), .a_wdata(a_wdata), .a_rdata(a_r),
        .b_addr(b_addr), .b_hold(b_hold), .b_re(b_re), .b_we(b_we), .b_wdata(b_wdata), .b_rdata(b_r)
    );

    task automatic chk(input string what, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    task automatic compare(input string t);
        chk({t, " raw A"}, a_r, ra);
        chk({t, " raw B"}, b_r, rb);
        chk({t, " R6 registered A"}, a_q, oa);
        chk({t, " R6 registered B"}, b_q, ob);
    endtask

    task automatic step(input vec_t v, input logic r);
        logic [AW-1:0] ea, eb;
        logic [DW-1:0] nra, nrb;
        a_we = v.wa; a_hold = v.ha; a_re = v.ra; a_addr = v.aa; a_wdata = v.da;
        b_we = v.wb; b_hold = v.hb; b_re = v.rb; b_addr = v.ab; b_wdata = v.db;
        rst = r;
        @(posedge clk);
        ea  = v.ha ? la : v.aa;
        eb  = v.hb ? lb : v.ab;
        nra = v.ra ? m[ea] : ra;
        nrb = v.rb ? m[eb] : rb;
        if (rqa) oa = ra;
        if (rqb) ob = rb;
        rqa = v.ra; rqb = v.rb;
        ra = nra; rb = nrb;
        la = ea; lb = eb;
        if (v.wb) m[eb] = v.db;
        if (v.wa) m[ea] = v.da;
        if (r) begin
            la = '0; lb = '0; ra = '0; rb = '0; oa = '0; ob = '0; rqa = 1'b0; rqb = 1'b0;
        end
        @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        vec_t idle;
        vec_t v;
        idle = '0;
        la = '0; lb = '0; ra = '0; rb = '0; oa = '0; ob = '0; rqa = 1'b0; rqb = 1'b0;
        rst = 1'b1;
        a_we = 0; a_hold = 0; a_re = 0; a_addr = '0; a_wdata = '0;
        b_we = 0; b_hold = 0; b_re = 0; b_addr = '0; b_wdata = '0;
        @(negedge clk);
        step(idle, 1'b1);
        step(idle, 1'b1);
        compare("R10 reset state");

        for (int i = 0; i < N; i++) begin
            step(VEC[i], 1'b0);
            compare(tag(i));
        end
        step(idle, 1'b0);
        compare("R6 drain");

        // R10: place a word at address 0, reset, then read through a held port
        v = '0; v.wa = 1'b1; v.aa = 4'd0; v.da = 8'h5A;
        step(v, 1'b0);
        v = '0; v.ra = 1'b1; v.aa = 4'd3; v.rb = 1'b1; v.ab = 4'd2;
        step(v, 1'b0);
        step(idle, 1'b0);
        compare("R10 before reset");
        step(idle, 1'b1);
        compare("R10 cleared");
        v = '0; v.ha = 1'b1; v.ra = 1'b1; v.aa = 4'd9; v.rb = 1'b1; v.ab = 4'd3;
        step(v, 1'b0);
        chk("R10 held address is 0 after reset", a_r, 8'h5A);
        chk("R10 memory kept", b_r, 8'hA3);
        step(idle, 1'b0);
        compare("R10 registered");

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule